// File: doc/BRIEF.md
# Trunk Line Status Indicator Controller

This block turns a handful of trunk-card condition flags into the two enables of a bicolour (red/green) status lamp. Every condition maps to one of three looks per colour: steady on, flashing, or dark. Flashing runs at a fixed rate with a 50% duty cycle. A prescaler inside the block derives that rate from the system clock.

The conditions have a fixed precedence. A power-section failure darkens the lamp whatever else is true. Below that, a fault lights red steadily, and the block also shows red while its own reset is held. Out-of-service flashes red and a busy in-service line flashes green. With no flag raised, the line is in service and free, which shows steady green. Both colours use one shared flash phase, so changing between a red and a green flashing condition does not restart the rhythm. Each enable comes from a register and follows its inputs one clock later.

Top module: `line_lamp_ctrl`

## Requirements
- R1: While `rst` is high, each clock edge sets `lamp_red` to 1 and `lamp_green` to 0. Reset also clears the flash prescaler, so the first flash phase after reset is the on phase.
- R2: When `fault_flag` is 1 and `pwr_fail` is 0, red is steadily on and green is off.
- R3: When `oos_flag` is 1 and neither `fault_flag` nor `pwr_fail` is 1, red flashes and green is off.
- R4: When `busy_flag` is 1 and none of `fault_flag`, `oos_flag` or `pwr_fail` is 1, green flashes and red is off.
- R5: When no flag is 1, green is steadily on and red is off.
- R6: Precedence from highest to lowest is `pwr_fail`, `fault_flag`, `oos_flag`, `busy_flag`, then free.
- R7: With `pwr_fail` at 1 outside reset, both enables are 0, whatever the other flags are.
- R8: The flash half period is HALF = CLK_HZ / (2 * FLASH_HZ) clocks. The output made at the k-th clock edge after reset release (k = 0, 1, ...) is in the on phase exactly when floor(k / HALF) is even. The phase is shared by both colours and keeps running through changes of condition.
- R9: `lamp_red` and `lamp_green` are never 1 in the same cycle.
- R10: Both enables are registered. A change of flags applied before a clock edge shows at the outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_fail | input | 1 | Power-section failure, forces the lamp dark |
| fault_flag | input | 1 | Card fault present |
| oos_flag | input | 1 | Line out of service |
| busy_flag | input | 1 | In-service line busy |
| lamp_red | output | 1 | Red lamp enable |
| lamp_green | output | 1 | Green lamp enable |

## Verification
The bench first holds each condition alone for several flash half periods. This separates steady red, steady green, flashing red, flashing green and dark. It then raises several flags at once to check the precedence order, with power failure set together with every other flag. It switches from out-of-service to busy in the middle of a phase, which shows that the two colours share one flash phase. Finally it applies reset in the middle of a flash, which shows that flashing restarts in the on phase.

// File: rtl/line_lamp_pkg.sv
package line_lamp_pkg;

    typedef enum logic [2:0] {
        LM_DARK  = 3'd0,
        LM_FAULT = 3'd1,
        LM_OOS   = 3'd2,
        LM_BUSY  = 3'd3,
        LM_FREE  = 3'd4
    } lamp_mode_e;

    typedef struct packed {
        logic pwr_fail;
        logic fault;
        logic oos;
        logic busy;
    } line_flags_t;

    typedef struct packed {
        logic red;
        logic green;
    } lamp_pair_t;

    function automatic int unsigned half_period(input int unsigned clk_hz,
                                                input int unsigned flash_hz);
        int unsigned h;
        h = clk_hz / (2 * flash_hz);
        return (h < 1) ? 1 : h;
    endfunction

    function automatic lamp_pair_t mode_to_lamp(input lamp_mode_e m,
                                                input logic on_phase);
        lamp_pair_t p;
        p = '0;
        case (m)
            LM_FAULT: p.red   = 1'b1;
            LM_OOS:   p.red   = on_phase;
            LM_BUSY:  p.green = on_phase;
            LM_FREE:  p.green = 1'b1;
            default:  p = '0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/lamp_flash_timebase.sv
module lamp_flash_timebase #(
    parameter int unsigned HALF = 4
) (
    input  logic clk,
    input  logic rst,
    output logic on_phase
);
    localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_q;
    logic          phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            phase_q <= 1'b1;
        end else if (cnt_q == LAST) begin
            cnt_q   <= '0;
            phase_q <= ~phase_q;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    assign on_phase = phase_q;

    p_count_bound_r8: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

    p_phase_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != LAST) |=> $stable(phase_q));

    p_reset_on_phase_r1: assert property (@(posedge clk)
        rst |=> (phase_q && cnt_q == '0));

endmodule

// File: rtl/lamp_state_arbiter.sv
module lamp_state_arbiter
    import line_lamp_pkg::*;
(
    input  line_flags_t flags,
    output lamp_mode_e  mode
);
    always_comb begin
        if (flags.pwr_fail)      mode = LM_DARK;
        else if (flags.fault)    mode = LM_FAULT;
        else if (flags.oos)      mode = LM_OOS;
        else if (flags.busy)     mode = LM_BUSY;
        else                     mode = LM_FREE;
    end
endmodule

// File: rtl/lamp_output_stage.sv
module lamp_output_stage
    import line_lamp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  lamp_mode_e mode,
    input  logic       on_phase,
    output lamp_pair_t lamp
);
    lamp_pair_t lamp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lamp_q.red   <= 1'b1;
            lamp_q.green <= 1'b0;
        end else begin
            lamp_q <= mode_to_lamp(mode, on_phase);
        end
    end

    assign lamp = lamp_q;

    p_one_colour_r9: assert property (@(posedge clk)
        !(lamp_q.red && lamp_q.green));

    p_reset_red_r1: assert property (@(posedge clk)
        rst |=> (lamp_q.red && !lamp_q.green));

    p_dark_when_needed_r7: assert property (@(posedge clk) disable iff (rst)
        (mode == LM_DARK) |=> (!lamp_q.red && !lamp_q.green));

    p_steady_red_r2: assert property (@(posedge clk) disable iff (rst)
        (mode == LM_FAULT) |=> (lamp_q.red && !lamp_q.green));

    p_steady_green_r5: assert property (@(posedge clk) disable iff (rst)
        (mode == LM_FREE) |=> (lamp_q.green && !lamp_q.red));
endmodule

// File: rtl/line_lamp_ctrl.sv
module line_lamp_ctrl
    import line_lamp_pkg::*;
#(
    parameter int unsigned CLK_HZ   = 125_000_000,
    parameter int unsigned FLASH_HZ = 60
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_fail,
    input  logic fault_flag,
    input  logic oos_flag,
    input  logic busy_flag,
    output logic lamp_red,
    output logic lamp_green
);
    localparam int unsigned HALF = half_period(CLK_HZ, FLASH_HZ);

    line_flags_t flags;
    lamp_mode_e  mode;
    logic        on_phase;
    lamp_pair_t  lamp;

    assign flags = '{pwr_fail: pwr_fail, fault: fault_flag,
                     oos: oos_flag, busy: busy_flag};

    lamp_flash_timebase #(.HALF(HALF)) u_timebase (
        .clk      (clk),
        .rst      (rst),
        .on_phase (on_phase)
    );

    lamp_state_arbiter u_arbiter (
        .flags (flags),
        .mode  (mode)
    );

    lamp_output_stage u_out (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .on_phase (on_phase),
        .lamp     (lamp)
    );

    assign lamp_red   = lamp.red;
    assign lamp_green = lamp.green;

    p_pwr_dark_r7: assert property (@(posedge clk) disable iff (rst)
        pwr_fail |=> (!lamp_red && !lamp_green));

    p_fault_over_flash_r6: assert property (@(posedge clk) disable iff (rst)
        (fault_flag && !pwr_fail) |=> (lamp_red && !lamp_green));

    p_busy_never_red_r4: assert property (@(posedge clk) disable iff (rst)
        (busy_flag && !oos_flag && !fault_flag && !pwr_fail) |=> !lamp_red);

    p_oos_never_green_r3: assert property (@(posedge clk) disable iff (rst)
        (oos_flag && !fault_flag && !pwr_fail) |=> !lamp_green);
endmodule

// File: tb/line_lamp_ctrl_tb_top.sv
module line_lamp_ctrl_tb_top;

    localparam int unsigned T_CLK_HZ   = 1200;
    localparam int unsigned T_FLASH_HZ = 60;
    localparam int unsigned T_HALF     = T_CLK_HZ / (2 * T_FLASH_HZ);

    typedef struct {
        logic  red;
        logic  green;
        string req;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwr_fail = 1'b0;
    logic fault_flag = 1'b0;
    logic oos_flag = 1'b0;
    logic busy_flag = 1'b0;
    logic lamp_red, lamp_green;

    exp_t exp_q[$];
    int   applied = 0;
    int   errors  = 0;
    int   k_since = 0;
    bit   done    = 1'b0;

    always #4 clk = ~clk;

    line_lamp_ctrl #(.CLK_HZ(T_CLK_HZ), .FLASH_HZ(T_FLASH_HZ)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .pwr_fail   (pwr_fail),
        .fault_flag (fault_flag),
        .oos_flag   (oos_flag),
        .busy_flag  (busy_flag),
        .lamp_red   (lamp_red),
        .lamp_green (lamp_green)
    );

    // Driver: sets inputs for the next edge and queues the expected result
    task automatic drive(input bit r, input bit pf, input bit ft,
                         input bit os, input bit bz, input string req);
        exp_t e;
        bit   on;
        @(negedge clk);
        rst = r; pwr_fail = pf; fault_flag = ft; oos_flag = os; busy_flag = bz;
        on = ((k_since / T_HALF) % 2) == 0;
        e.req = req;
        if (r)       begin e.red = 1'b1; e.green = 1'b0; end
        else if (pf) begin e.red = 1'b0; e.green = 1'b0; end
        else if (ft) begin e.red = 1'b1; e.green = 1'b0; end
        else if (os) begin e.red = on;   e.green = 1'b0; end
        else if (bz) begin e.red = 1'b0; e.green = on;   end
        else         begin e.red = 1'b0; e.green = 1'b1; end
        exp_q.push_back(e);
        if (r) k_since = 0;
        else   k_since++;
    endtask

    task automatic hold(input int n, input bit r, input bit pf, input bit ft,
                        input bit os, input bit bz, input string req);
        for (int i = 0; i < n; i++) drive(r, pf, ft, os, bz, req);
    endtask

    // Monitor: compares after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                applied++;
                if (lamp_red !== e.red || lamp_green !== e.green) begin
                    errors++;
                    $display("FAIL %s: red/green = %b%b, expected %b%b",
                             e.req, lamp_red, lamp_green, e.red, e.green);
                end
                if (lamp_red === 1'b1 && lamp_green === 1'b1) begin
                    errors++;
                    $display("FAIL R9: red/green = 11, expected not both on");
                end
            end
        end
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 200000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run not finished, expected done");
            $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
            $finish;
        end
    end

    initial begin
        hold(3, 1, 0, 0, 0, 0, "R1 reset");
        hold(4, 0, 0, 0, 0, 0, "R5 free steady green");
        hold(4, 0, 0, 1, 0, 0, "R2 fault steady red");
        hold(3 * T_HALF, 0, 0, 0, 1, 0, "R3 oos red flash R8");
        hold(3 * T_HALF, 0, 0, 0, 0, 1, "R4 busy green flash R8");
        hold(T_HALF, 0, 0, 1, 1, 1, "R6 fault over oos and busy");
        hold(2 * T_HALF, 0, 0, 0, 1, 1, "R6 oos over busy");
        hold(3, 0, 1, 1, 1, 1, "R7 power fail over all");
        hold(3, 0, 1, 0, 0, 0, "R7 power fail alone");
        hold(3, 0, 0, 0, 0, 0, "R10 change seen one edge later");
        hold(T_HALF / 2 + 1, 0, 0, 0, 1, 0, "R8 shared phase oos");
        hold(T_HALF + 2, 0, 0, 0, 0, 1, "R8 shared phase busy");
        hold(2, 1, 0, 0, 1, 0, "R1 reset mid flash");
        hold(2 * T_HALF, 0, 0, 0, 1, 0, "R1 flash restarts on R3");
        hold(3, 1, 1, 0, 0, 0, "R1 reset while power fail");
        hold(2, 0, 0, 0, 0, 0, "R5 free after reset");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
        $finish;
    end

endmodule